// File: doc/BRIEF.md
# Serial Bus Register Access Target

This block is the target side of a two-wire serial bus for a small register device. It samples the open-drain clock and data lines in the system clock domain and recognises bus start, repeated start and stop conditions. An access opens with an identity byte: a fixed four-bit prefix followed by three bits that must match strap pins, and then a direction bit. A register-address byte follows.

A write carries exactly one data byte, which is handed to an external register bank as a single-cycle write strobe. For a read, the master sends a repeated start and an identity byte with the direction bit set. The block then streams bytes from the bank, MSB first, for as long as the master acknowledges. The register pointer steps after each acknowledged byte and wraps from 0Fh back to 00h.

The block only pulls the data line low, through an output enable. It never drives the line high. While the device is still coming out of power-up, start conditions are not recognised.

Top module: `i2c_reg_target`

## Requirements
- R1: Until a start condition (data falling while clock is high) is seen, the block ignores all bus traffic, and sda_oe_o is 0 after reset and whenever the block is idle.
- R2: The identity byte is accepted only if its upper seven bits equal 1010 followed by strap_i[2:0], sent MSB first. Its LSB selects read (1) or write (0). A matching byte is acknowledged by holding data low during the ninth clock. A byte that does not match is not acknowledged, and the block stays silent until the next start.
- R3: After a write identity byte, the next byte is acknowledged and loaded into the register pointer, which appears on reg_addr_o.
- R4: The first data byte after the address byte is acknowledged and produces exactly one single-cycle reg_we_o pulse, with reg_addr_o equal to the pointer and reg_wdata_o equal to the byte. Any further bytes in the same write are neither acknowledged nor written.
- R5: After a repeated start and a read identity byte, the block sends the bank byte at the pointer, MSB first. After each master acknowledge, the pointer advances and the next byte is sent.
- R6: When the pointer advances from 0Fh, it wraps to 00h.
- R7: A master not-acknowledge after a read byte ends the read. The data line stays released until the next start.
- R8: A stop or start that arrives partway through a byte aborts that transfer, and no register write is issued for it.
- R9: Start conditions are ignored while boot_busy_i is 1.
- R10: sda_oe_o is only asserted following a falling edge of the bus clock, so the block changes the data line only while the clock is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull data line low when 1 |
| strap_i | input | 3 | Identity strap bits, MSB first on the bus |
| boot_busy_i | input | 1 | Power-up sequence in progress |
| reg_addr_o | output | AW | Register pointer to the bank |
| reg_we_o | output | 1 | Single-cycle write strobe |
| reg_wdata_o | output | 8 | Write data |
| reg_rdata_i | input | 8 | Bank data at reg_addr_o (combinational) |

## Verification
Two functions compete for the same cycle: committing a received data byte to the bank, and aborting on a bus start or stop. The bench cuts a write byte short with a stop, and separately with a repeated start. It then checks through the scoreboard queue that no strobe appears. It also reads the untouched location back and compares it with the bench's own shadow copy. Full bytes that end right at a boundary must still commit once, and any extra bytes in the same write must not commit.

// File: rtl/i2c_reg_pkg.sv
package i2c_reg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_TXACK, ST_TXGO, ST_WAIT
  } st_e;

  typedef enum logic [1:0] {K_ID, K_REG, K_WDATA, K_DONE} kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  localparam int NLINES = 2;

  logic [NLINES-1:0] raw, lvl, prev;
  assign raw = {scl_i, sda_i};

  for (genvar g = 0; g < NLINES; g++) begin : g_line
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff <= '1;
      else         ff <= {ff[STAGES-2:0], raw[g]};
    end
    assign lvl[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev <= '1;
    else         prev <= lvl;
  end

  assign scl_o      = lvl[1];
  assign sda_o      = lvl[0];
  assign scl_rise_o = lvl[1] & ~prev[1];
  assign scl_fall_o = ~lvl[1] & prev[1];
  // data edges while clock held high
  assign start_o    = lvl[1] & prev[1] & prev[0] & ~lvl[0];
  assign stop_o     = lvl[1] & prev[1] & ~prev[0] & lvl[0];
endmodule

// File: rtl/i2c_reg_ptr.sv
module i2c_reg_ptr #(
  parameter int AW        = 8,
  parameter int WRAP_LAST = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          inc_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] LAST = AW'(WRAP_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_o <= '0;
    else if (load_i) ptr_o <= load_val_i;
    else if (inc_i)  ptr_o <= (ptr_o == LAST) ? '0 : ptr_o + 1'b1;
  end

  p_wrap_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && ptr_o == LAST) |=> ptr_o == '0);
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
  import i2c_reg_pkg::*;
#(
  parameter int          AW          = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [3:0]  ID_PREFIX   = 4'b1010,
  parameter int          WRAP_LAST   = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic [2:0]    strap_i,
  input  logic          boot_busy_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_we_o,
  output logic [7:0]    reg_wdata_o,
  input  logic [7:0]    reg_rdata_i
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  logic scl, sda, scl_rise, scl_fall, start, stop;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .scl_i, .sda_i,
    .scl_o(scl), .sda_o(sda), .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(start), .stop_o(stop)
  );

  st_e          st;
  kind_e        kind, nkind;
  logic         go_tx;
  logic [7:0]   sh;
  logic [CW-1:0] bcnt;
  logic         oe, we, ld, inc;
  logic [7:0]   wdata;

  i2c_reg_ptr #(.AW(AW), .WRAP_LAST(WRAP_LAST)) u_ptr (
    .clk_i, .rst_ni, .load_i(ld), .load_val_i(AW'(sh)), .inc_i(inc),
    .ptr_o(reg_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st <= ST_IDLE; kind <= K_ID; nkind <= K_ID; go_tx <= 1'b0;
      sh <= '0; bcnt <= '0; oe <= 1'b0; we <= 1'b0; wdata <= '0;
      ld <= 1'b0; inc <= 1'b0;
    end else begin
      we <= 1'b0; ld <= 1'b0; inc <= 1'b0;
      if (stop) begin
        st <= ST_IDLE; oe <= 1'b0;
      end else if (start && !boot_busy_i) begin
        st <= ST_RX; kind <= K_ID; bcnt <= '0; oe <= 1'b0;
      end else begin
        unique case (st)
          ST_RX: begin
            if (scl_rise) begin
              sh   <= {sh[6:0], sda};
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall && bcnt == CW'(BITS)) begin
              unique case (kind)
                K_ID: begin
                  if (sh[7:1] == {ID_PREFIX, strap_i}) begin
                    oe <= 1'b1; st <= ST_ACK; go_tx <= sh[0]; nkind <= K_REG;
                  end else begin
                    st <= ST_WAIT;
                  end
                end
                K_REG: begin
                  ld <= 1'b1; oe <= 1'b1; st <= ST_ACK; go_tx <= 1'b0; nkind <= K_WDATA;
                end
                K_WDATA: begin
                  we <= 1'b1; wdata <= sh; oe <= 1'b1; st <= ST_ACK;
                  go_tx <= 1'b0; nkind <= K_DONE;
                end
                default: st <= ST_WAIT;   // surplus write byte: no ack
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              bcnt <= '0;
              if (go_tx) begin
                sh <= reg_rdata_i; oe <= ~reg_rdata_i[7]; st <= ST_TX;
              end else begin
                oe <= 1'b0; kind <= nkind; st <= ST_RX;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bcnt <= bcnt + 1'b1;
            end else if (scl_fall) begin
              if (bcnt == CW'(BITS)) begin
                oe <= 1'b0; st <= ST_TXACK;
              end else begin
                sh <= {sh[6:0], 1'b0}; oe <= ~sh[6];
              end
            end
          end
          ST_TXACK: begin
            if (scl_rise) begin
              if (sda) st <= ST_WAIT;
              else begin inc <= 1'b1; st <= ST_TXGO; end
            end
          end
          ST_TXGO: begin
            if (scl_fall) begin
              bcnt <= '0; sh <= reg_rdata_i; oe <= ~reg_rdata_i[7]; st <= ST_TX;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe;
  assign reg_we_o    = we;
  assign reg_wdata_o = wdata;

  p_idle_release_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE) |-> !sda_oe_o);
  p_we_single_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);
  p_nack_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_TXACK && scl_rise && sda && !stop && !start) |=> (st == ST_WAIT && !sda_oe_o));
  p_stop_abort_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop |=> (st == ST_IDLE && !sda_oe_o && !reg_we_o));
  p_boot_ignore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_IDLE && start && boot_busy_i) |=> st == ST_IDLE);
  p_oe_after_fall_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_o) |-> $past(scl_fall));
endmodule

// File: tb/tb_i2c_reg_target.sv
module tb_i2c_reg_target;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] ID_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] ID_R = {4'b1010, STRAP, 1'b1};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1, boot = 1'b0;
  logic sda_oe, we;
  logic [7:0] addr, wdata, rdata;
  wire sda_line = sda_m & ~sda_oe;

  i2c_reg_target dut (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .strap_i(STRAP), .boot_busy_i(boot),
    .reg_addr_o(addr), .reg_we_o(we), .reg_wdata_o(wdata), .reg_rdata_i(rdata)
  );

  int checks = 0, fails = 0;
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  logic [15:0] exp_q [$];
  logic oe_seen = 1'b0, oe_d = 1'b0, done = 1'b0;

  assign rdata = mem[addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  // bank + scoreboard monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 1);
    end else begin
      if (we) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R4/R8 unexpected write actual %0h expected none", {addr, wdata});
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if ({addr, wdata} !== e) begin
            fails++;
            $display("FAIL R4 write actual %0h expected %0h", {addr, wdata}, e);
          end
        end
        mem[addr] <= wdata;
      end
      oe_d <= sda_oe;
      if (sda_oe) oe_seen <= 1'b1;
      if (sda_oe && !oe_d) begin
        checks++;
        if (scl_m) begin
          fails++;
          $display("FAIL R10 oe rose with clock actual 1 expected 0");
        end
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic bstart(); sda_m = 1; wq(); scl_m = 1; wq(); sda_m = 0; wq(); scl_m = 0; wq(); endtask
  task automatic bstop(); sda_m = 0; wq(); scl_m = 1; wq(); sda_m = 1; wq(); endtask
  task automatic clk_bit(input logic b, output logic s);
    sda_m = b; wq(); scl_m = 1; wq(); s = sda_line; wq(); scl_m = 0; wq();
  endtask
  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    ack = !s;
  endtask
  task automatic recv_byte(output logic [7:0] b, input logic nack);
    logic s;
    for (int i = 7; i >= 0; i--) begin clk_bit(1'b1, s); b[i] = s; end
    clk_bit(nack, s);
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    logic k;
    exp_q.push_back({a, d});
    shadow[a] = d;
    bstart();
    send_byte(ID_W, k); chk("R2 id ack", k, 1);
    send_byte(a, k);    chk("R3 addr ack", k, 1);
    send_byte(d, k);    chk("R4 data ack", k, 1);
    bstop();
  endtask

  task automatic read_setup(input logic [7:0] a);
    logic k;
    bstart();
    send_byte(ID_W, k); chk("R2 id ack", k, 1);
    send_byte(a, k);    chk("R3 addr ack", k, 1);
    bstart();
    send_byte(ID_R, k); chk("R5 read id ack", k, 1);
  endtask

  initial begin
    logic k, s;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) shadow[i] = 8'(i * 7 + 1);
    repeat (4) @(negedge clk);
    chk("R1 reset oe", sda_oe, 0);
    chk("R4 reset we", we, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // R1: bytes without a start
    scl_m = 0; wq();
    for (int i = 7; i >= 0; i--) clk_bit(ID_W[i], s);
    clk_bit(1'b1, s);
    sda_m = 1; wq(); scl_m = 1; wq();
    chk("R1 no response without start", oe_seen, 0);

    // R2..R4
    do_write(8'h03, 8'hA5);
    exp_q.push_back({8'h04, 8'h3C}); shadow[8'h04] = 8'h3C;
    bstart();
    send_byte(ID_W, k); send_byte(8'h04, k); send_byte(8'h3C, k);
    chk("R4 first data ack", k, 1);
    send_byte(8'h77, k);
    chk("R4 surplus byte no ack", k, 0);
    bstop();

    // R5 streaming read with increment
    read_setup(8'h03);
    recv_byte(b, 1'b0); chk("R5 byte0", b, shadow[3]);
    recv_byte(b, 1'b0); chk("R5 byte1", b, shadow[4]);
    recv_byte(b, 1'b1); chk("R5 byte2", b, shadow[5]);
    // R7: after nack, line stays released
    recv_byte(b, 1'b1); chk("R7 released after nack", b, 8'hFF);
    bstop();

    // R6 wrap
    read_setup(8'h0E);
    recv_byte(b, 1'b0); chk("R6 0E", b, shadow[8'h0E]);
    recv_byte(b, 1'b0); chk("R6 0F", b, shadow[8'h0F]);
    recv_byte(b, 1'b1); chk("R6 wrap 00", b, shadow[8'h00]);
    bstop();

    // R8 abort by stop mid data byte
    bstart();
    send_byte(ID_W, k); send_byte(8'h05, k);
    for (int i = 0; i < 4; i++) clk_bit(i[0], s);
    bstop();
    // R8 abort by repeated start, then a clean write
    bstart();
    send_byte(ID_W, k); send_byte(8'h06, k);
    for (int i = 0; i < 5; i++) clk_bit(1'b1, s);
    exp_q.push_back({8'h07, 8'h11}); shadow[8'h07] = 8'h11;
    bstart();
    send_byte(ID_W, k); send_byte(8'h07, k); send_byte(8'h11, k);
    chk("R8 write after restart ack", k, 1);
    bstop();
    read_setup(8'h05);
    recv_byte(b, 1'b0); chk("R8 loc5 untouched", b, shadow[5]);
    recv_byte(b, 1'b0); chk("R8 loc6 untouched", b, shadow[6]);
    recv_byte(b, 1'b1); chk("R8 loc7 written", b, 8'h11);
    bstop();

    // R2 wrong strap
    oe_seen = 1'b0;
    bstart();
    send_byte({4'b1010, 3'b100, 1'b0}, k); chk("R2 mismatch no ack", k, 0);
    send_byte(8'h02, k);                   chk("R2 silent after mismatch", k, 0);
    bstop();
    send_byte(8'h00, k);
    chk("R2 no drive at all", oe_seen, 0);

    // R9 boot
    boot = 1'b1; oe_seen = 1'b0;
    bstart();
    send_byte(ID_W, k); chk("R9 start ignored in boot", k, 0);
    bstop();
    chk("R9 no drive in boot", oe_seen, 0);
    boot = 1'b0;
    do_write(8'h09, 8'h5A);

    repeat (10) @(negedge clk);
    chk("R4 scoreboard drained", exp_q.size(), 0);
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule